// File: doc/BRIEF.md
# Pulse-Width Bit Serialiser

This block drives one output line with a frame of data bits, where each bit is told apart only by how long the line stays high. Every bit gets a slot of a fixed number of clock cycles. The line goes high at the start of the slot and stays high for a short time for a zero or a long time for a one. It then stays low until the slot ends. Slots follow one another with no idle cycle between them, so the whole frame runs with exact timing. With the default 48 MHz clock, a slot of 60 cycles splits 17/43 for a zero and 43/17 for a one. A frame of 360 bits then takes about 450 µs.

A host pulses a start input while the block is idle, then streams bits through a valid/ready input. The first accepted bit starts the first slot on the next cycle. After that, the next bit has to arrive by the last cycle of the current slot. The block holds at most one bit ahead in a single-entry store, and can also take a bit straight from the input in the cycle the slot ends. At the end of the frame the line drops low and a done pulse is given. If a bit is missing when it is needed, the frame stops and an underflow flag is raised.

Top module: `pwe_tx`

## Requirements
- R1: After reset, `line_o`, `busy_o`, `done_o`, `underflow_o` and `bit_ready_o` are all low.
- R2: A `start_i` pulse while idle sets `busy_o` high in the next cycle and clears `underflow_o` in that same cycle.
- R3: Each slot lasts exactly SLOT_TICKS cycles. The first slot starts in the cycle after the first bit handshake (`bit_valid_i && bit_ready_o` at a clock edge). Later slots follow with no gap.
- R4: In its slot, a bit of value 0 holds `line_o` high for HIGH_ZERO cycles and a bit of value 1 holds it high for HIGH_ONE cycles; the line is low for the rest of the slot. Bits go out in the order they were accepted.
- R5: A frame holds FRAME_BITS slots. In the cycle after the last slot's final cycle, `line_o` is low, `busy_o` is low and `done_o` is high for exactly one cycle. The line then stays low.
- R6: The block accepts at most one bit per slot ahead of the running one. `bit_ready_o` is low while such a bit is held, while idle, and during the last slot of a frame.
- R7: After start, `line_o` stays low and `busy_o` stays high for as long as the first bit is withheld.
- R8: A bit offered only in the final cycle of a slot is taken directly. It is sent in the next slot with no gap and no underflow.
- R9: If no bit is available at the end of a slot that is not the last one, the frame stops. In the next cycle `line_o` and `busy_o` are low, `underflow_o` is high and `done_o` stays low. `underflow_o` stays high until the next accepted start.
- R10: A `start_i` pulse while busy has no effect: the frame's timing, bit order and done cycle are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a frame (used only while idle) |
| bit_valid_i | input | 1 | A data bit is offered |
| bit_data_i | input | 1 | The offered bit value |
| bit_ready_o | output | 1 | The block will take the offered bit at this edge |
| line_o | output | 1 | Pulse-width encoded serial output |
| busy_o | output | 1 | A frame is pending or in progress |
| done_o | output | 1 | One-cycle pulse after the last slot |
| underflow_o | output | 1 | Frame stopped because a bit was missing; held until next start |

## Verification
The hardest case to reach is a bit that arrives in the very cycle the slot ends. The store is empty then, so the bit has to pass straight from the input to the slot timer. Normal streaming never reaches this path, because it refills the store early in each slot. To get there, the stimulus withholds `bit_valid_i` for the whole slot and raises it only in the cycle before the slot-ending edge. That edge is found by counting cycles from the first handshake. A second scheme stops supplying bits partway through a frame. This forces the stop path and shows the flag stays set until the next start is accepted.

// File: rtl/pwe_pkg.sv
package pwe_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_PRIME = 2'd1,
      PH_SEND  = 2'd2
   } pwe_phase_e;

   function automatic int unsigned pwe_cw(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/pwe_slot_timer.sv
module pwe_slot_timer #(
   parameter int unsigned SLOT_TICKS = 60,
   parameter int unsigned HIGH_ZERO  = 17,
   parameter int unsigned HIGH_ONE   = 43,
   parameter bit          REG_LINE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch_i,
   input  logic halt_i,
   input  logic bit_i,
   output logic slot_end_o,
   output logic line_o
);
   localparam int unsigned TW = pwe_pkg::pwe_cw(SLOT_TICKS);
   localparam logic [TW-1:0] LAST_TICK = TW'(SLOT_TICKS - 1);
   localparam logic [TW-1:0] HI_ZERO   = TW'(HIGH_ZERO);
   localparam logic [TW-1:0] HI_ONE    = TW'(HIGH_ONE);

   logic          run_q, run_d;
   logic [TW-1:0] tick_q, tick_d;
   logic          bit_q, bit_d;

   always_comb begin
      run_d  = run_q;
      tick_d = tick_q;
      bit_d  = bit_q;
      if (launch_i) begin
         run_d  = 1'b1;
         tick_d = '0;
         bit_d  = bit_i;
      end else if (halt_i) begin
         run_d  = 1'b0;
         tick_d = '0;
      end else if (run_q) begin
         tick_d = (tick_q == LAST_TICK) ? '0 : tick_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         tick_q <= '0;
         bit_q  <= 1'b0;
      end else begin
         run_q  <= run_d;
         tick_q <= tick_d;
         bit_q  <= bit_d;
      end
   end

   assign slot_end_o = run_q && (tick_q == LAST_TICK);

   generate
      if (REG_LINE) begin : g_line_reg
         logic line_q;
         always_ff @(posedge clk) begin
            if (!rst_n) line_q <= 1'b0;
            else        line_q <= run_d && (tick_d < (bit_d ? HI_ONE : HI_ZERO));
         end
         assign line_o = line_q;
      end else begin : g_line_comb
         assign line_o = run_q && (tick_q < (bit_q ? HI_ONE : HI_ZERO));
      end
   endgenerate

   // The line may only rise on the first tick of a running slot.
   assert_rise_at_slot_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_o) |-> (run_q && tick_q == '0));

   // The last tick of each slot is always low.
   assert_tail_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && tick_q == LAST_TICK) |-> !line_o);

endmodule

// File: rtl/pwe_bit_store.sv
module pwe_bit_store (
   input  logic clk,
   input  logic rst_n,
   input  logic want_i,
   input  logic take_i,
   input  logic in_valid_i,
   input  logic in_data_i,
   output logic ready_o,
   output logic have_o,
   output logic bit_o
);
   logic full_q;
   logic data_q;
   logic accept;

   assign ready_o = want_i && !full_q;
   assign accept  = in_valid_i && ready_o;
   assign have_o  = full_q || accept;
   assign bit_o   = full_q ? data_q : in_data_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= 1'b0;
      end else if (take_i) begin
         full_q <= 1'b0;
      end else if (accept) begin
         full_q <= 1'b1;
         data_q <= in_data_i;
      end
   end

   // A held bit is only ever dropped by the consumer.
   assert_hold_until_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && !take_i) |=> (full_q && $stable(data_q)));

endmodule

// File: rtl/pwe_frame_ctrl.sv
module pwe_frame_ctrl
   import pwe_pkg::*;
#(
   parameter int unsigned FRAME_BITS = 360
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic have_bit_i,
   input  logic slot_end_i,
   output logic launch_o,
   output logic halt_o,
   output logic take_o,
   output logic want_o,
   output logic busy_o,
   output logic done_o,
   output logic underflow_o
);
   localparam int unsigned CW = pwe_cw(FRAME_BITS);
   localparam logic [CW-1:0] LAST_BIT = CW'(FRAME_BITS - 1);

   pwe_phase_e    phase_q, phase_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          done_q, done_d;
   logic          uf_q, uf_d;
   logic          last_slot;

   assign last_slot = (cnt_q == LAST_BIT);

   always_comb begin
      phase_d  = phase_q;
      cnt_d    = cnt_q;
      done_d   = 1'b0;
      uf_d     = uf_q;
      launch_o = 1'b0;
      halt_o   = 1'b0;
      take_o   = 1'b0;
      want_o   = 1'b0;
      unique case (phase_q)
         PH_IDLE: begin
            if (start_i) begin
               phase_d = PH_PRIME;
               cnt_d   = '0;
               uf_d    = 1'b0;
            end
         end
         PH_PRIME: begin
            want_o = 1'b1;
            if (have_bit_i) begin
               launch_o = 1'b1;
               take_o   = 1'b1;
               phase_d  = PH_SEND;
            end
         end
         PH_SEND: begin
            want_o = !last_slot;
            if (slot_end_i) begin
               if (last_slot) begin
                  halt_o  = 1'b1;
                  done_d  = 1'b1;
                  phase_d = PH_IDLE;
               end else if (have_bit_i) begin
                  launch_o = 1'b1;
                  take_o   = 1'b1;
                  cnt_d    = cnt_q + 1'b1;
               end else begin
                  halt_o  = 1'b1;
                  uf_d    = 1'b1;
                  phase_d = PH_IDLE;
               end
            end
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
         uf_q    <= 1'b0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
         done_q  <= done_d;
         uf_q    <= uf_d;
      end
   end

   assign busy_o      = (phase_q != PH_IDLE);
   assign done_o      = done_q;
   assign underflow_o = uf_q;

   // A start seen mid-frame leaves the sending phase alone.
   assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_SEND && start_i && !slot_end_i) |=> (phase_q == PH_SEND));

   // A stop for lack of data never produces a done pulse.
   assert_underflow_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(uf_q) |-> (!busy_o && !done_q));

endmodule

// File: rtl/pwe_tx.sv
module pwe_tx #(
   parameter int unsigned SLOT_TICKS = 60,
   parameter int unsigned HIGH_ZERO  = 17,
   parameter int unsigned HIGH_ONE   = 43,
   parameter int unsigned FRAME_BITS = 360,
   parameter bit          REG_LINE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic bit_valid_i,
   input  logic bit_data_i,
   output logic bit_ready_o,
   output logic line_o,
   output logic busy_o,
   output logic done_o,
   output logic underflow_o
);
   generate
      if (SLOT_TICKS < 2) begin : g_bad_slot
         $error("pwe_tx: SLOT_TICKS must be at least 2");
      end
      if (HIGH_ZERO < 1 || HIGH_ZERO >= SLOT_TICKS) begin : g_bad_hz
         $error("pwe_tx: HIGH_ZERO must lie in 1..SLOT_TICKS-1");
      end
      if (HIGH_ONE < 1 || HIGH_ONE >= SLOT_TICKS) begin : g_bad_ho
         $error("pwe_tx: HIGH_ONE must lie in 1..SLOT_TICKS-1");
      end
      if (HIGH_ZERO == HIGH_ONE) begin : g_bad_same
         $error("pwe_tx: the two high times must differ");
      end
      if (FRAME_BITS < 1) begin : g_bad_frame
         $error("pwe_tx: FRAME_BITS must be at least 1");
      end
   endgenerate

   logic launch, halt, take, want, have_bit, next_bit, slot_end;

   pwe_frame_ctrl #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .have_bit_i  (have_bit),
      .slot_end_i  (slot_end),
      .launch_o    (launch),
      .halt_o      (halt),
      .take_o      (take),
      .want_o      (want),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .underflow_o (underflow_o)
   );

   pwe_bit_store u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .want_i     (want),
      .take_i     (take),
      .in_valid_i (bit_valid_i),
      .in_data_i  (bit_data_i),
      .ready_o    (bit_ready_o),
      .have_o     (have_bit),
      .bit_o      (next_bit)
   );

   pwe_slot_timer #(
      .SLOT_TICKS (SLOT_TICKS),
      .HIGH_ZERO  (HIGH_ZERO),
      .HIGH_ONE   (HIGH_ONE),
      .REG_LINE   (REG_LINE)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch_i   (launch),
      .halt_i     (halt),
      .bit_i      (next_bit),
      .slot_end_o (slot_end),
      .line_o     (line_o)
   );

   assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !line_o);

   // A slot handed over at a slot boundary starts high on the very next cycle.
   assert_gapless_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_end && launch) |=> line_o);

   assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_ready_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bit_ready_o |-> busy_o);

endmodule

// File: tb/tb_pwe_tx.sv
`timescale 1ns/1ps
module tb_pwe_tx;
   localparam int SLOT = 8;
   localparam int H0   = 2;
   localparam int H1   = 5;
   localparam int FB   = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic bit_valid_i = 1'b0;
   logic bit_data_i = 1'b0;
   logic bit_ready_o, line_o, busy_o, done_o, underflow_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   pwe_tx #(.SLOT_TICKS(SLOT), .HIGH_ZERO(H0), .HIGH_ONE(H1), .FRAME_BITS(FB)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .bit_valid_i(bit_valid_i),
      .bit_data_i(bit_data_i), .bit_ready_o(bit_ready_o), .line_o(line_o),
      .busy_o(busy_o), .done_o(done_o), .underflow_o(underflow_o));

   task automatic chk(input logic act, input logic exp, input string req, input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // mode 0: stream bits eagerly; 1: offer each later bit only on a slot's final cycle;
   // 2: supply only nb bits, then stop. d0 delays the first bit, inj pulses start mid-frame.
   task automatic run_frame(input logic [FB-1:0] pat, input int mode, input int nb,
                            input int d0, input int inj);
      int idx = 0;
      int k = -1;
      bit started = 0;
      bit finished = 0;
      int lim = (mode == 2) ? nb : FB;
      int end_k = lim * SLOT;
      @(negedge clk);
      start_i = 1'b1;
      bit_valid_i = 1'b0;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o, 1'b1, "R2", "busy after start");
      chk(underflow_o, 1'b0, "R2", "underflow cleared by start");
      for (int cyc = 0; cyc < 400 && !finished; cyc++) begin
         logic v;
         logic hs;
         if (!started) begin
            chk(line_o, 1'b0, "R7", "line low awaiting first bit");
            chk(busy_o, 1'b1, "R7", "busy awaiting first bit");
         end else if (k < end_k) begin
            logic b;
            b = pat[k / SLOT];
            chk(line_o, ((k % SLOT) < (b ? H1 : H0)), (b ? "R4" : "R3"), "line in slot");
            chk(busy_o, 1'b1, "R3", "busy during frame");
            chk(done_o, 1'b0, "R5", "no early done");
            chk(underflow_o, 1'b0, "R8", "no underflow while fed");
         end else begin
            chk(line_o, 1'b0, "R5", "line low at end");
            chk(busy_o, 1'b0, "R5", "idle at end");
            chk(done_o, (mode != 2), (mode == 2) ? "R9" : "R5", "done at end");
            chk(underflow_o, (mode == 2), "R9", "underflow at end");
            chk(bit_ready_o, 1'b0, "R6", "not ready when idle");
            finished = 1;
         end
         if (finished) break;
         start_i = started && (k == inj);
         v = 1'b0;
         if (!started) v = (cyc >= d0);
         else if (idx < lim) v = (mode == 1) ? (((k + 1) % SLOT) == 0) : 1'b1;
         bit_valid_i = v;
         bit_data_i = (idx < FB) ? pat[idx] : 1'b0;
         hs = v && bit_ready_o;
         @(posedge clk);
         if (started) k++;
         if (hs) begin
            if (!started) begin
               started = 1;
               k = 0;
            end
            idx++;
         end
         @(negedge clk);
      end
      bit_valid_i = 1'b0;
      start_i = 1'b0;
      chk(finished, 1'b1, "R5", "frame reached its end");
      @(posedge clk);
      @(negedge clk);
      chk(done_o, 1'b0, "R5", "done lasts one cycle");
      chk(line_o, 1'b0, "R5", "line stays low after frame");
      chk(underflow_o, (mode == 2), "R9", "underflow held while idle");
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk(line_o, 1'b0, "R1", "reset line");
      chk(busy_o, 1'b0, "R1", "reset busy");
      chk(done_o, 1'b0, "R1", "reset done");
      chk(underflow_o, 1'b0, "R1", "reset underflow");
      chk(bit_ready_o, 1'b0, "R1", "reset ready");
      // R3 R4 R5 R6: sweep every bit pattern with eager streaming
      for (int p = 0; p < (1 << FB); p++) run_frame(FB'(p), 0, 0, 0, -1);
      // R7: first bit withheld
      run_frame(6'b110010, 0, 0, 3, -1);
      // R8: every later bit arrives just in time
      run_frame(6'b101101, 1, 0, 0, -1);
      run_frame(6'b010011, 1, 0, 2, -1);
      // R10: start pulsed mid-frame
      run_frame(6'b011001, 0, 0, 0, 10);
      run_frame(6'b100110, 0, 0, 0, SLOT * FB - 1);
      // R9: supply stops after two bits, then a new start clears the flag
      run_frame(6'b111111, 2, 2, 0, -1);
      run_frame(6'b000011, 0, 0, 0, -1);
      run_frame(6'b010101, 2, 1, 0, -1);
      run_frame(6'b101010, 1, 0, 0, -1);
      summary();
      $finish;
   end
endmodule